// File: doc/BRIEF.md
# Keyed Watchdog Reset Timer

This block is a hardware watchdog that asks for a system reset when software stops servicing it. After chip reset it is idle and can never request a reset. Software arms it by writing a two-value key, in order, to a write-only service port. The same two-value key, written again later, restarts the timeout window. Once armed, the watchdog stays armed until the next chip reset.

While armed, a wide counter advances on every peripheral clock. A 3-bit selector picks which upper counter bit marks the end of the window, so the window is one of seven powers of two. When the selected bit sets, the block drives a reset request. The request stays high for a fixed number of clocks and then drops. The counter is held at zero while the request is high, and it starts a new window once the request is released.

A service routine, including the interrupt handler that wakes the core from idle, should write the key often enough that the counter never reaches the selected bit.

Top module: `wdog_timer`

## Requirements
- R1: After `rst_n` is released, `wd_reset_o` and `wd_run_o` are both low.
- R2: The key is written in two steps. A write of 1Eh is followed by a write of E1h, and no other write may come between them, although idle cycles between the two writes are allowed. The clock edge that accepts the E1h write arms the timer, clears the counter, and sets `wd_run_o` high at that same edge.
- R3: If any other write value comes between 1Eh and E1h, the key is aborted. A lone write of E1h does not arm the timer either. In both cases `wd_run_o` stays low.
- R4: While the timer is not armed, `wd_reset_o` never rises, however many cycles pass.
- R5: Selector value N (0 to 6) gives a window of T = 2^(BASE_TAP+N) cycles. If the key is accepted at clock edge k, `wd_reset_o` rises at edge k+T+1.
- R6: Selector value 7 gives the same window as value 6.
- R7: A new key sequence that completes before expiry restarts the window, measured from the edge that accepts the new E1h write.
- R8: `wd_reset_o` stays high for exactly HOLD_CYC clocks (96 by default) and then falls.
- R9: `wd_run_o` stays high through a reset request and through any non-key write. If the edge where `wd_reset_o` falls is F, the next request rises at F+T+1 unless the key is written first.
- R10: `svc_rdata` reads as all ones at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| tmo_sel | input | SEL_W (3) | Window selector |
| svc_wr | input | 1 | Write strobe for the service port |
| svc_wdata | input | KEY_W (8) | Write data for the service port |
| svc_rdata | output | KEY_W (8) | Read value of the service port (all ones) |
| wd_reset_o | output | 1 | System reset request |
| wd_run_o | output | 1 | Timer armed status |

## Verification
The armed status is due at the same edge that accepts the second key write. A reset request is due T+1 edges after that edge, where T is the window length. The request falls HOLD_CYC edges after it rises, and the next request rises T+1 edges after that fall. The driver numbers each accepting edge and pushes the edge numbers of every expected rise and fall into a queue. The monitor samples at the falling clock edge, pops the queue on each change of `wd_reset_o`, and flags a change that comes at a different edge or that was never queued. The bench shortens the counter so that every window fits in a short run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Maps a selector value to the counter bit that ends the window.
  // Values above top_sel saturate to top_sel.
  function automatic int unsigned sel_to_tap(input int unsigned sel,
                                             input int unsigned base,
                                             input int unsigned top_sel);
    return base + ((sel > top_sel) ? top_sel : sel);
  endfunction

  // Window length in cycles for a given tap bit.
  function automatic int unsigned tap_window(input int unsigned tap);
    return 32'd1 << tap;
  endfunction

endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq #(
  parameter int unsigned KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_ARM = 8'h1E,
  parameter logic [KEY_W-1:0] KEY_GO  = 8'hE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [KEY_W-1:0] wdata,
  output logic             kick_o
);
  logic primed_q;

  // Every write re-evaluates the first half of the key; idle cycles keep it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  primed_q <= 1'b0;
    else if (wr) primed_q <= (wdata == KEY_ARM);
  end

  assign kick_o = wr && primed_q && (wdata == KEY_GO);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned CNT_W = 21,
  parameter int unsigned TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [TAP_W-1:0] tap,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign hit_o = cnt_q[tap];
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
  parameter int unsigned HOLD_CYC = 96,
  localparam int unsigned HOLD_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active_o
);
  logic              active_q;
  logic [HOLD_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else if (!active_q) begin
      if (fire) begin
        active_q <= 1'b1;
        left_q   <= HOLD_W'(HOLD_CYC - 1);
      end
    end else if (left_q == '0) begin
      active_q <= 1'b0;
    end else begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned CNT_W    = 21,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned BASE_TAP = 14,
  parameter int unsigned TOP_SEL  = 6,
  parameter int unsigned HOLD_CYC = 96,
  parameter int unsigned KEY_W    = 8,
  parameter logic [KEY_W-1:0] KEY_ARM = 8'h1E,
  parameter logic [KEY_W-1:0] KEY_GO  = 8'hE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] tmo_sel,
  input  logic             svc_wr,
  input  logic [KEY_W-1:0] svc_wdata,
  output logic [KEY_W-1:0] svc_rdata,
  output logic             wd_reset_o,
  output logic             wd_run_o
);
  localparam int unsigned TAP_W = $clog2(CNT_W);

  logic             kick_evt;
  logic             expire_evt;
  logic             cnt_hit;
  logic             armed_q;
  logic [TAP_W-1:0] tap_idx;
  logic [CNT_W-1:0] cnt_q;

  assign tap_idx = TAP_W'(wdog_pkg::sel_to_tap(32'(tmo_sel), BASE_TAP, TOP_SEL));

  wdog_key_seq #(.KEY_W(KEY_W), .KEY_ARM(KEY_ARM), .KEY_GO(KEY_GO)) key_i (
    .clk(clk), .rst_n(rst_n), .wr(svc_wr), .wdata(svc_wdata), .kick_o(kick_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (kick_evt) armed_q <= 1'b1;
  end

  wdog_count #(.CNT_W(CNT_W), .TAP_W(TAP_W)) cnt_i (
    .clk(clk), .rst_n(rst_n),
    .clr(kick_evt | expire_evt | wd_reset_o),
    .en(armed_q), .tap(tap_idx), .cnt_o(cnt_q), .hit_o(cnt_hit)
  );

  assign expire_evt = armed_q && !wd_reset_o && cnt_hit;

  wdog_stretch #(.HOLD_CYC(HOLD_CYC)) hold_i (
    .clk(clk), .rst_n(rst_n), .fire(expire_evt), .active_o(wd_reset_o)
  );

  assign wd_run_o  = armed_q;
  assign svc_rdata = '1;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int unsigned CNT_W    = 21,
  parameter int unsigned HOLD_CYC = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             kick_evt,
  input logic             expire_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wd_reset_o,
  input logic             wd_run_o
);
  localparam int unsigned HL_W = $clog2(HOLD_CYC + 1) + 1;
  logic [HL_W-1:0] hl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hl <= '0;
    else if (wd_reset_o) hl <= hl + 1'b1;
    else                 hl <= '0;
  end

  a_r2_kick_arms: assert property (@(posedge clk) disable iff (!rst_n)
    kick_evt |=> wd_run_o);
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_run_o |-> !wd_reset_o);
  a_r5_expire_fires: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> $rose(wd_reset_o));
  a_r8_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset_o |-> (hl < HL_W'(HOLD_CYC)));
  a_r8_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_reset_o) |-> (hl == HL_W'(HOLD_CYC)));
  a_r9_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wd_run_o |=> wd_run_o);
  a_r9_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset_o |-> (cnt_q == '0));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .kick_evt(kick_evt), .expire_evt(expire_evt),
  .cnt_q(cnt_q), .wd_reset_o(wd_reset_o), .wd_run_o(wd_run_o)
);

// File: tb/wdog_timer_tb_top.sv
module wdog_timer_tb_top;
  localparam int CNT_W = 12;
  localparam int BASE  = 5;
  localparam int HOLD  = 96;

  typedef struct {
    int    cyc;
    bit    val;
    string req;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] tmo_sel = 3'd0;
  logic       svc_wr = 1'b0;
  logic [7:0] svc_wdata = 8'h00;
  logic [7:0] svc_rdata;
  logic       wd_reset_o, wd_run_o;

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  prev_rst = 1'b0;
  ev_t exp_q[$];

  wdog_timer #(.CNT_W(CNT_W), .BASE_TAP(BASE), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .tmo_sel(tmo_sel), .svc_wr(svc_wr),
    .svc_wdata(svc_wdata), .svc_rdata(svc_rdata),
    .wd_reset_o(wd_reset_o), .wd_run_o(wd_run_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int win(input int sel);
    return 1 << (BASE + ((sel > 6) ? 6 : sel));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic svc_write(input logic [7:0] v, output int k);
    @(negedge clk);
    svc_wr = 1'b1;
    svc_wdata = v;
    @(negedge clk);
    k = cyc;
    svc_wr = 1'b0;
  endtask

  task automatic kick(output int k);
    int d;
    svc_write(8'h1E, d);
    svc_write(8'hE1, k);
  endtask

  task automatic expect_pulse(input int rise, input string req);
    exp_q.push_back('{rise, 1'b1, req});
    exp_q.push_back('{rise + HOLD, 1'b0, "R8"});
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Monitor: every change of the reset request must match the queue head.
  always @(negedge clk) begin
    if (!rst_n) prev_rst <= 1'b0;
    else if (wd_reset_o != prev_rst) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected edge", cyc, -1);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(e.cyc == cyc && e.val == wd_reset_o, e.req, cyc, e.cyc);
      end
      prev_rst <= wd_reset_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R5 actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, f, d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wd_reset_o == 1'b0, "R1 reset low", int'(wd_reset_o), 0);
    chk(wd_run_o == 1'b0, "R1 run low", int'(wd_run_o), 0);
    chk(svc_rdata == 8'hFF, "R10 rdata", int'(svc_rdata), 255);

    // R4: unarmed for a long time, no request
    repeat (3000) @(negedge clk);
    chk(wd_reset_o == 1'b0, "R4 unarmed", int'(wd_reset_o), 0);

    // R3: aborted or partial keys
    svc_write(8'hE1, d);
    chk(wd_run_o == 1'b0, "R3 lone second key", int'(wd_run_o), 0);
    svc_write(8'h1E, d);
    svc_write(8'h55, d);
    svc_write(8'hE1, d);
    chk(wd_run_o == 1'b0, "R3 interrupted key", int'(wd_run_o), 0);
    chk(svc_rdata == 8'hFF, "R10 rdata after writes", int'(svc_rdata), 255);

    // R2: idle cycles between the key halves are allowed
    svc_write(8'h1E, d);
    repeat (3) @(negedge clk);
    svc_write(8'hE1, k);
    chk(wd_run_o == 1'b1, "R2 armed", int'(wd_run_o), 1);
    expect_pulse(k + win(0) + 1, "R5 sel0");
    wait_done();
    chk(wd_run_o == 1'b1, "R9 run after pulse", int'(wd_run_o), 1);

    // R7: second kick restarts the window
    tmo_sel = 3'd2;
    kick(k);
    repeat (100) @(negedge clk);
    kick(k);
    expect_pulse(k + win(2) + 1, "R7 restart");
    f = k + win(2) + 1 + HOLD;
    wait_done();

    // R9: refire without service, non-key write does not disarm
    expect_pulse(f + win(2) + 1, "R9 refire");
    svc_write(8'h00, d);
    chk(wd_run_o == 1'b1, "R9 run after other write", int'(wd_run_o), 1);
    wait_done();

    // R6: selector 7 behaves as 6
    tmo_sel = 3'd7;
    kick(k);
    expect_pulse(k + win(6) + 1, "R6 sel7");
    wait_done();
    tmo_sel = 3'd6;
    kick(k);
    expect_pulse(k + win(6) + 1, "R5 sel6");
    wait_done();

    chk(svc_rdata == 8'hFF, "R10 rdata final", int'(svc_rdata), 255);
    chk(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule